// File: doc/BRIEF.md
# Port and Timer Register Window

This block sits on a small controller's peripheral register bus and answers for a narrow window of internal registers: two port direction registers, two port output latches and the control/status byte of the timer. The CPU side presents an address, a write byte, a write strobe and a read strobe, and gets the selected byte back one clock after the read strobe. Two 8-bit pin buses come in from the package. For each port the block puts out a direction vector and a drive vector.

A port read is assembled bit by bit. An input bit reads the live pin and an output bit reads the stored latch. The first port keeps the whole written byte and loads its drive vector at the moment of the write: latch bits on output positions, current pin values on input positions. The second port has only five real output lines, because its top three pins carry the operating-mode straps. A write to it updates only the bits the direction register marks as outputs, and the stored value is clipped to bits 4:0. The timer byte places three flags from the timer (read-only here) above five control bits that the bus can write. A read of it raises a one-cycle strobe that tells the timer its status has been seen.

Top module: `periph_regwin`

## Requirements
- R1: After a synchronous reset all direction vectors, drive vectors, timer control bits, read data and the status-read strobe are 0x00/0, so every pin starts as an input.
- R2: Only address bits 4:0 select a register; higher address bits are ignored, so an address such as 0x0022 or 0xFFE0 aliases offset 0x02 or 0x00.
- R3: Offsets 0x00 and 0x01 hold the first and second port direction registers (1 = output); a write stores the full byte, shown on the port's direction output and read back at the same offset.
- R4: A read of offset 0x02 or 0x03 returns, for each bit, the latch bit when that direction bit is 1 and the pin bit when it is 0; read data appears in the cycle after the read strobe.
- R5: A write to offset 0x02 stores the whole byte in the first port latch and loads the first port drive vector with (pins AND NOT direction) OR (data AND direction), sampled at that write; the drive vector holds until the next such write.
- R6: A write to offset 0x03 sets the second port latch to ((old AND NOT direction) OR (data AND direction)) AND 0x1F; the second port drive vector equals that latch, so its bits 7:5 are always 0.
- R7: A read of offset 0x08 returns {flags[2:0], control[4:0]} and pulses the status-read strobe high for exactly the one cycle in which that read data is presented.
- R8: A write to offset 0x08 changes only the five control bits (4:0); the three flag bits always follow the timer's flag inputs.
- R9: Reads of any other offset return 0x00, and writes to them change no register.
- R10: In any cycle that does not follow a read strobe, the read data output is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (16) | Register address; bits 4:0 decoded |
| bus_wdata | input | 8 | Write byte |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read byte |
| pa_pins_i | input | 8 | First port pin levels |
| pa_dir_o | output | 8 | First port direction (1 = output) |
| pa_drive_o | output | 8 | First port drive vector |
| pb_pins_i | input | 8 | Second port pin levels; bits 7:5 are mode straps |
| pb_dir_o | output | 8 | Second port direction (1 = output) |
| pb_drive_o | output | 8 | Second port drive vector, bits 7:5 zero |
| tmr_flags_i | input | 3 | Timer flags, shown in status bits 7:5 |
| tmr_ctrl_o | output | 5 | Timer control bits 4:0 |
| tmr_stat_rd_o | output | 1 | One-cycle pulse after a status read |

## Verification
The properties assume that the bus never raises the write and read strobes in the same cycle. They also assume that the pin and flag inputs change only between clock edges. The stimulus drives every strobe, address and pin change on the falling edge and issues one access per cycle, so both assumptions hold. Hold properties check that a register or drive vector does not move unless a write hits its offset, and that the status strobe is only ever preceded by a read of 0x08. The bench covers aliased addresses, partial direction masks and the port that ignores its input-direction bits.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int DEC_W = 5;
  localparam int BYTE_W = 8;
  localparam logic [DEC_W-1:0] OFS_DIR_A  = 5'h00;
  localparam logic [DEC_W-1:0] OFS_DIR_B  = 5'h01;
  localparam logic [DEC_W-1:0] OFS_DAT_A  = 5'h02;
  localparam logic [DEC_W-1:0] OFS_DAT_B  = 5'h03;
  localparam logic [DEC_W-1:0] OFS_TSTAT  = 5'h08;

  typedef struct packed {
    logic dir_a;
    logic dir_b;
    logic dat_a;
    logic dat_b;
    logic tstat;
  } regsel_t;

  function automatic regsel_t decode_ofs(input logic [DEC_W-1:0] ofs);
    regsel_t s;
    s.dir_a = (ofs == OFS_DIR_A);
    s.dir_b = (ofs == OFS_DIR_B);
    s.dat_a = (ofs == OFS_DAT_A);
    s.dat_b = (ofs == OFS_DAT_B);
    s.tstat = (ofs == OFS_TSTAT);
    return s;
  endfunction
endpackage

// File: rtl/regwin_port.sv
module regwin_port #(
  parameter int         W            = 8,
  parameter logic [W-1:0] LATCH_MASK = '1,
  parameter bit         MASKED_STORE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_we,
  input  logic         dat_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pins,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] drive_o,
  output logic [W-1:0] rd_o
);
  logic [W-1:0] dir_q;
  logic [W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (rst)         dir_q <= '0;
    else if (dir_we) dir_q <= wdata;
  end

  generate
    if (MASKED_STORE) begin : g_masked
      // only output-direction bits take the new value
      always_ff @(posedge clk) begin
        if (rst)         lat_q <= '0;
        else if (dat_we) lat_q <= ((lat_q & ~dir_q) | (wdata & dir_q)) & LATCH_MASK;
      end
      assign drive_o = lat_q;
    end else begin : g_plain
      logic [W-1:0] drv_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lat_q <= '0;
          drv_q <= '0;
        end else if (dat_we) begin
          lat_q <= wdata & LATCH_MASK;
          drv_q <= (pins & ~dir_q) | (wdata & dir_q);
        end
      end
      assign drive_o = drv_q;
    end
  endgenerate

  for (genvar i = 0; i < W; i++) begin : g_merge
    assign rd_o[i] = dir_q[i] ? lat_q[i] : pins[i];
  end

  assign dir_o = dir_q;
endmodule

// File: rtl/regwin_tstat.sv
module regwin_tstat #(
  parameter int CTRL_W = 5,
  parameter int FLAG_W = 3,
  localparam int STAT_W = CTRL_W + FLAG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [STAT_W-1:0] rd_o,
  output logic              rd_pulse_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= wdata;
      pulse_q <= rd_en;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign rd_o       = {flags_i, ctrl_q};
  assign rd_pulse_o = pulse_q;
endmodule

// File: rtl/periph_regwin.sv
module periph_regwin
  import regwin_pkg::*;
#(
  parameter int AW     = 16,
  parameter int CTRL_W = 5,
  parameter int FLAG_W = 3,
  parameter int PB_OUT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        pa_pins_i,
  output logic [7:0]        pa_dir_o,
  output logic [7:0]        pa_drive_o,
  input  logic [7:0]        pb_pins_i,
  output logic [7:0]        pb_dir_o,
  output logic [7:0]        pb_drive_o,
  input  logic [FLAG_W-1:0] tmr_flags_i,
  output logic [CTRL_W-1:0] tmr_ctrl_o,
  output logic              tmr_stat_rd_o
);
  localparam logic [BYTE_W-1:0] PB_MASK = BYTE_W'((1 << PB_OUT) - 1);

  logic              unused_addr_hi;
  regsel_t           sel;
  logic [BYTE_W-1:0] rd_a, rd_b, rd_t, rd_mux, rdata_q;

  assign unused_addr_hi = ^bus_addr[AW-1:DEC_W];
  assign sel = decode_ofs(bus_addr[DEC_W-1:0]);

  regwin_port #(.W(BYTE_W), .LATCH_MASK('1), .MASKED_STORE(1'b0)) u_port_a (
    .clk(clk), .rst(rst),
    .dir_we(bus_we && sel.dir_a), .dat_we(bus_we && sel.dat_a),
    .wdata(bus_wdata), .pins(pa_pins_i),
    .dir_o(pa_dir_o), .drive_o(pa_drive_o), .rd_o(rd_a)
  );

  regwin_port #(.W(BYTE_W), .LATCH_MASK(PB_MASK), .MASKED_STORE(1'b1)) u_port_b (
    .clk(clk), .rst(rst),
    .dir_we(bus_we && sel.dir_b), .dat_we(bus_we && sel.dat_b),
    .wdata(bus_wdata), .pins(pb_pins_i),
    .dir_o(pb_dir_o), .drive_o(pb_drive_o), .rd_o(rd_b)
  );

  regwin_tstat #(.CTRL_W(CTRL_W), .FLAG_W(FLAG_W)) u_tstat (
    .clk(clk), .rst(rst),
    .wr_en(bus_we && sel.tstat), .rd_en(bus_re && sel.tstat),
    .wdata(bus_wdata[CTRL_W-1:0]), .flags_i(tmr_flags_i),
    .ctrl_o(tmr_ctrl_o), .rd_o(rd_t), .rd_pulse_o(tmr_stat_rd_o)
  );

  always_comb begin
    rd_mux = '0;
    if (sel.dir_a)      rd_mux = pa_dir_o;
    else if (sel.dir_b) rd_mux = pb_dir_o;
    else if (sel.dat_a) rd_mux = rd_a;
    else if (sel.dat_b) rd_mux = rd_b;
    else if (sel.tstat) rd_mux = rd_t;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bus_re ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
  parameter int AW     = 16,
  parameter int CTRL_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_rdata,
  input logic [7:0]        pa_dir_o,
  input logic [7:0]        pa_drive_o,
  input logic [7:0]        pb_drive_o,
  input logic [CTRL_W-1:0] tmr_ctrl_o,
  input logic              tmr_stat_rd_o
);
  logic [4:0] ofs;
  assign ofs = bus_addr[4:0];

  // R6: upper three lines of the second port are never driven high
  a_r6_pb_hi_zero: assert property (@(posedge clk) disable iff (rst)
    pb_drive_o[7:5] == 3'b000);

  // R7: strobe only after a status read
  a_r7_strobe_src: assert property (@(posedge clk) disable iff (rst)
    !(bus_re && ofs == 5'h08) |=> !tmr_stat_rd_o);

  // R10: idle read data
  a_r10_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> bus_rdata == 8'h00);

  // R3: direction register holds without a write to its offset
  a_r3_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && ofs == 5'h00) |=> $stable(pa_dir_o));

  // R5: drive vector holds between writes
  a_r5_drive_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && ofs == 5'h02) |=> $stable(pa_drive_o));

  // R8: control bits hold without a status write
  a_r8_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && ofs == 5'h08) |=> $stable(tmr_ctrl_o));
endmodule

bind periph_regwin regwin_chk #(.AW(AW), .CTRL_W(CTRL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .pa_dir_o(pa_dir_o), .pa_drive_o(pa_drive_o),
  .pb_drive_o(pb_drive_o), .tmr_ctrl_o(tmr_ctrl_o), .tmr_stat_rd_o(tmr_stat_rd_o)
);

// File: tb/sim_periph_regwin.sv
module sim_periph_regwin;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pa_pins_i = 8'hA5, pa_dir_o, pa_drive_o;
  logic [7:0]  pb_pins_i = 8'hEC, pb_dir_o, pb_drive_o;
  logic [2:0]  tmr_flags_i = 3'b101;
  logic [4:0]  tmr_ctrl_o;
  logic        tmr_stat_rd_o;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  periph_regwin u0 (.*);

  // {is_read, addr, wdata, expected read byte}
  localparam int NV = 12;
  localparam logic [32:0] VEC [NV] = '{
    {1'b0, 16'h0000, 8'h0F, 8'h00},
    {1'b0, 16'h0002, 8'h3C, 8'h00},
    {1'b1, 16'h0002, 8'h00, 8'hAC},
    {1'b0, 16'h0001, 8'h33, 8'h00},
    {1'b0, 16'h0003, 8'hFF, 8'h00},
    {1'b1, 16'h0003, 8'h00, 8'hDF},
    {1'b1, 16'h0001, 8'h00, 8'h33},
    {1'b0, 16'h0008, 8'hFF, 8'h00},
    {1'b1, 16'h0008, 8'h00, 8'hBF},
    {1'b1, 16'h0005, 8'h00, 8'h00},
    {1'b1, 16'h0022, 8'h00, 8'hAC},
    {1'b1, 16'h0000, 8'h00, 8'h0F}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 pa_dir", pa_dir_o, 8'h00);
    check("R1 pb_dir", pb_dir_o, 8'h00);
    check("R1 pa_drive", pa_drive_o, 8'h00);
    check("R1 pb_drive", pb_drive_o, 8'h00);
    check("R1 ctrl", {3'b000, tmr_ctrl_o}, 8'h00);
    check("R1 rdata/strobe", {bus_rdata[6:0], tmr_stat_rd_o}, 8'h00);

    // table walk: R3 R4 R5 R6 R7 R8 R9, R2 via alias 0x0022
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][32]) begin
        rd(VEC[i][31:16], rv);
        check($sformatf("R4/R2/R9 vec %0d", i), rv, VEC[i][7:0]);
      end else begin
        wr(VEC[i][31:16], VEC[i][15:8]);
      end
    end

    // R10 idle cycle after a read
    @(negedge clk);
    check("R10 idle rdata", bus_rdata, 8'h00);

    // R5 drive vector captured at write and held
    check("R5 drive after write", pa_drive_o, 8'hAC);
    pa_pins_i = 8'h00;
    @(negedge clk);
    check("R5 drive holds on pin change", pa_drive_o, 8'hAC);
    pa_pins_i = 8'h5A;
    wr(16'h0002, 8'hF0);
    check("R5 drive mix", pa_drive_o, 8'h50);
    wr(16'h0000, 8'hFF);
    rd(16'h0002, rv);
    check("R5 full latch byte", rv, 8'hF0);
    check("R3 pa_dir", pa_dir_o, 8'hFF);

    // R6 ignored input bits and mask
    wr(16'h0001, 8'h00);
    wr(16'h0003, 8'hFF);
    check("R6 input bits ignored", pb_drive_o, 8'h13);
    wr(16'h0001, 8'hFF);
    check("R3 pb_dir", pb_dir_o, 8'hFF);
    wr(16'h0003, 8'hFF);
    check("R6 masked latch", pb_drive_o, 8'h1F);
    rd(16'h0003, rv);
    check("R6 read all-output", rv, 8'h1F);

    // R7 strobe timing
    @(negedge clk); bus_re = 1'b1; bus_addr = 16'h0008;
    check("R7 strobe not early", {7'd0, tmr_stat_rd_o}, 8'h00);
    @(negedge clk); bus_re = 1'b0;
    check("R7 strobe high", {7'd0, tmr_stat_rd_o}, 8'h01);
    check("R7 status byte", bus_rdata, 8'hBF);
    @(negedge clk);
    check("R7 strobe one cycle", {7'd0, tmr_stat_rd_o}, 8'h00);

    // R8 flags not writable
    tmr_flags_i = 3'b000;
    wr(16'h0008, 8'hE0);
    check("R8 ctrl", {3'b000, tmr_ctrl_o}, 8'h00);
    rd(16'h0008, rv);
    check("R8 flags ignore write", rv, 8'h00);
    tmr_flags_i = 3'b111;
    rd(16'h0008, rv);
    check("R8 flags follow input", rv, 8'hE0);

    // R9 unused write changes nothing
    wr(16'h0010, 8'h00);
    check("R9 pa_dir kept", pa_dir_o, 8'hFF);
    check("R9 pb_drive kept", pb_drive_o, 8'h1F);

    // R2 aliased write
    wr(16'hFFE0, 8'h0F);
    check("R2 alias write", pa_dir_o, 8'h0F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule